// File: doc/BRIEF.md
# Composite Sync Flywheel Clamp Generator

This block produces one clamp pulse per video line, placed on the back porch after the horizontal sync tip, for the input clamps of a video digitiser. It runs on the sample clock. A single input carries either composite sync or a ready-made clamp pulse. A clamp-enable select decides which of the two it is, and a standard select picks the line length.

When clamping is enabled, a free-running line counter marks out the horizontal period. Each sync tip is checked on both edges. The falling edge must land close to the position the counter predicts. The tip width, measured from the falling edge to the rising edge, must fall inside a fixed range. A falling edge that passes the position check re-phases the counter. Edges that fail the check are ignored, so a missing, noisy or mistimed sync leaves the clamp pulse where the counter predicted it. A lock flag follows a run of good lines and a run of bad lines.

When clamping is disabled, the generator is held idle and the input is passed to the clamp output through one register.

Top module: `hsync_flywheel_clamp`

## Requirements
- R1: With clamp_en high and no accepted sync edge, clamp_out rising edges repeat every 910 clocks when std_pal is 0 and every 1136 clocks when std_pal is 1.
- R2: While clamp_en is low, clamp_out equals the value sync_in had one clock earlier and locked is low. During reset, clamp_out and locked are both low.
- R3: sync_in low is the sync tip. After an accepted falling edge, clamp_out rises 93 clocks after the edge is presented and stays high for exactly 32 clocks. The 93 clocks are 2 for edge detection, a delay of 90 and 1 for the output register.
- R4: While locked is low, every falling edge of sync_in is accepted and re-phases the line counter, wherever it lands.
- R5: While locked is high, a falling edge is accepted only if it lands within 8 clocks either side of the predicted line start. An edge 9 or more clocks off is ignored, and the clamp stays on the predicted position.
- R6: A sync tip counts as good only if its falling edge was accepted and its width, from the falling to the rising edge, is 60 to 80 clocks inclusive. Widths of 59 or 81 count as bad.
- R7: Each line is judged once, at counter position 85. locked rises after 4 consecutive good lines and never rises without sync.
- R8: locked falls after 8 consecutive bad lines. A line is bad when its sync is missing, its edge is ignored or its width is out of range. Clamp pulses continue on the predicted grid throughout.
- R9: When clamp_en rises, the counter restarts at position 0 with locked low. With no sync, the first clamp_out rise comes 91 clocks after the enable is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_in | input | 1 | Composite sync (low = tip) or external clamp pulse |
| clamp_en | input | 1 | 1: generate clamp from sync; 0: pass sync_in through |
| std_pal | input | 1 | Line standard: 0 = 910 clocks, 1 = 1136 clocks |
| clamp_out | output | 1 | Registered clamp pulse |
| locked | output | 1 | Sync lock flag |

## Verification
The generator is tried with five kinds of input, each separating a different behaviour:
- An idle sync input in both standards tells the NTSC line length from the PAL one.
- A train of on-time tips started at an arbitrary point tells acquisition from windowed tracking.
- Tips shifted by exactly 8 and 9 clocks, early and late, place the edge of the acceptance window.
- Tip widths of 59, 60, 80 and 81 place the width limits through the lock flag.
- A sync that stops altogether shows the flywheel carrying the clamp on while the lock drops after the eighth empty line.

// File: rtl/hfc_pkg.sv
`timescale 1ns/1ps
package hfc_pkg;

  // Line length for the selected standard.
  function automatic int unsigned line_len(input logic pal, input int unsigned ntsc_n,
                                           input int unsigned pal_n);
    return pal ? pal_n : ntsc_n;
  endfunction

  // An on-time edge is seen at position len-1; the window spans +-win around it.
  function automatic logic edge_in_window(input int unsigned pos, input int unsigned len,
                                          input int unsigned win);
    if (pos >= len) return 1'b0;
    if (pos >= len / 2) return (len - 1 - pos) <= win;
    return (pos + 1) <= win;
  endfunction

  function automatic logic width_ok(input int unsigned w, input int unsigned lo,
                                    input int unsigned hi);
    return (w >= lo) && (w <= hi);
  endfunction

  function automatic logic in_clamp(input int unsigned pos, input int unsigned start,
                                    input int unsigned len);
    return (pos >= start) && (pos < start + len);
  endfunction

endpackage

// File: rtl/hfc_edge_sense.sv
`timescale 1ns/1ps
module hfc_edge_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  output logic sync_lvl,
  output logic fall_evt,
  output logic rise_evt
);
  logic s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= sync_in;
      s2 <= s1;
    end
  end

  assign sync_lvl = s1;
  assign fall_evt = s2 & ~s1;
  assign rise_evt = ~s2 & s1;
endmodule

// File: rtl/hfc_line_counter.sv
`timescale 1ns/1ps
module hfc_line_counter
  import hfc_pkg::*;
#(
  parameter int NTSC_LEN    = 910,
  parameter int PAL_LEN     = 1136,
  parameter int FALL_WIN    = 8,
  parameter int CLAMP_DLY   = 90,
  parameter int CLAMP_LEN   = 32,
  parameter int VERDICT_POS = 85,
  parameter int CNT_W       = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             std_pal,
  input  logic             fall_evt,
  input  logic             locked,
  output logic [CNT_W-1:0] pos,
  output logic             accept_fall,
  output logic             verdict,
  output logic             clamp_win
);
  int unsigned cur_len;
  logic        at_end;
  logic        win_hit;

  always_comb begin
    cur_len     = line_len(std_pal, NTSC_LEN, PAL_LEN);
    at_end      = 32'(pos) >= cur_len - 1;
    win_hit     = edge_in_window(32'(pos), cur_len, FALL_WIN);
    accept_fall = run && fall_evt && (!locked || win_hit);
    verdict     = run && (32'(pos) == VERDICT_POS);
    clamp_win   = run && in_clamp(32'(pos), CLAMP_DLY, CLAMP_LEN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pos <= '0;
    else if (!run)        pos <= '0;
    else if (accept_fall) pos <= '0;
    else if (at_end)      pos <= '0;
    else                  pos <= pos + 1'b1;
  end
endmodule

// File: rtl/hfc_pulse_judge.sv
`timescale 1ns/1ps
module hfc_pulse_judge
  import hfc_pkg::*;
#(
  parameter int RISE_MIN = 60,
  parameter int RISE_MAX = 80,
  parameter int LOCK_IN  = 4,
  parameter int LOCK_OUT = 8,
  parameter int WID_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             sync_lvl,
  input  logic             fall_evt,
  input  logic             rise_evt,
  input  logic             accept_fall,
  input  logic             verdict,
  output logic [WID_W-1:0] tip_width,
  output logic             line_good,
  output logic             locked
);
  localparam int WID_CAP = RISE_MAX + 1;
  localparam int GOOD_W  = $clog2(LOCK_IN + 1);
  localparam int BAD_W   = $clog2(LOCK_OUT + 1);

  logic              fall_ok;
  logic              pulse_ok;
  logic [GOOD_W-1:0] good_run;
  logic [BAD_W-1:0]  bad_run;

  assign pulse_ok = rise_evt && fall_ok && width_ok(32'(tip_width), RISE_MIN, RISE_MAX);

  // Tip width: 1 in the cycle after the falling edge, saturating past the limit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       tip_width <= '0;
    else if (fall_evt)                                tip_width <= WID_W'(1);
    else if (!sync_lvl && tip_width != WID_W'(WID_CAP)) tip_width <= tip_width + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    fall_ok <= 1'b0;
    else if (!run)                 fall_ok <= 1'b0;
    else if (accept_fall)          fall_ok <= 1'b1;
    else if (fall_evt || rise_evt) fall_ok <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        line_good <= 1'b0;
    else if (!run)     line_good <= 1'b0;
    else if (verdict)  line_good <= 1'b0;
    else if (pulse_ok) line_good <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_run <= '0;
      bad_run  <= '0;
      locked   <= 1'b0;
    end else if (!run) begin
      good_run <= '0;
      bad_run  <= '0;
      locked   <= 1'b0;
    end else if (verdict) begin
      if (line_good) begin
        bad_run <= '0;
        if (32'(good_run) < LOCK_IN) good_run <= good_run + 1'b1;
        if (32'(good_run) + 1 >= LOCK_IN) locked <= 1'b1;
      end else begin
        good_run <= '0;
        if (32'(bad_run) < LOCK_OUT) bad_run <= bad_run + 1'b1;
        if (32'(bad_run) + 1 >= LOCK_OUT) locked <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hsync_flywheel_clamp.sv
`timescale 1ns/1ps
module hsync_flywheel_clamp #(
  parameter int NTSC_LEN  = 910,
  parameter int PAL_LEN   = 1136,
  parameter int FALL_WIN  = 8,
  parameter int RISE_MIN  = 60,
  parameter int RISE_MAX  = 80,
  parameter int CLAMP_DLY = 90,
  parameter int CLAMP_LEN = 32,
  parameter int LOCK_IN   = 4,
  parameter int LOCK_OUT  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic clamp_en,
  input  logic std_pal,
  output logic clamp_out,
  output logic locked
);
  localparam int LEN_MAX     = (PAL_LEN > NTSC_LEN) ? PAL_LEN : NTSC_LEN;
  localparam int CNT_W       = $clog2(LEN_MAX);
  localparam int WID_W       = $clog2(RISE_MAX + 2);
  localparam int VERDICT_POS = RISE_MAX + 5;

  // Named internal events, observed by the bound checker.
  logic             sync_lvl;
  logic             fall_evt;
  logic             rise_evt;
  logic [CNT_W-1:0] pos;
  logic             accept_fall;
  logic             verdict;
  logic             clamp_win;
  logic [WID_W-1:0] tip_width;
  logic             line_good;

  hfc_edge_sense u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_in  (sync_in),
    .sync_lvl (sync_lvl),
    .fall_evt (fall_evt),
    .rise_evt (rise_evt)
  );

  hfc_line_counter #(
    .NTSC_LEN    (NTSC_LEN),
    .PAL_LEN     (PAL_LEN),
    .FALL_WIN    (FALL_WIN),
    .CLAMP_DLY   (CLAMP_DLY),
    .CLAMP_LEN   (CLAMP_LEN),
    .VERDICT_POS (VERDICT_POS),
    .CNT_W       (CNT_W)
  ) u_line (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (clamp_en),
    .std_pal     (std_pal),
    .fall_evt    (fall_evt),
    .locked      (locked),
    .pos         (pos),
    .accept_fall (accept_fall),
    .verdict     (verdict),
    .clamp_win   (clamp_win)
  );

  hfc_pulse_judge #(
    .RISE_MIN (RISE_MIN),
    .RISE_MAX (RISE_MAX),
    .LOCK_IN  (LOCK_IN),
    .LOCK_OUT (LOCK_OUT),
    .WID_W    (WID_W)
  ) u_judge (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (clamp_en),
    .sync_lvl    (sync_lvl),
    .fall_evt    (fall_evt),
    .rise_evt    (rise_evt),
    .accept_fall (accept_fall),
    .verdict     (verdict),
    .tip_width   (tip_width),
    .line_good   (line_good),
    .locked      (locked)
  );

  // Registered output: generated window or the raw input in bypass.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clamp_out <= 1'b0;
    else        clamp_out <= clamp_en ? clamp_win : sync_in;
  end
endmodule

// File: rtl/hfc_checker.sv
`timescale 1ns/1ps
module hfc_checker #(
  parameter int NTSC_LEN  = 910,
  parameter int PAL_LEN   = 1136,
  parameter int FALL_WIN  = 8,
  parameter int RISE_MIN  = 60,
  parameter int RISE_MAX  = 80,
  parameter int CLAMP_DLY = 90,
  parameter int CNT_W     = 11,
  parameter int WID_W     = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_in,
  input logic             clamp_en,
  input logic             std_pal,
  input logic             clamp_out,
  input logic             locked,
  input logic [CNT_W-1:0] pos,
  input logic             fall_evt,
  input logic             accept_fall,
  input logic             verdict,
  input logic [WID_W-1:0] tip_width,
  input logic             line_good
);
  logic [31:0] len_now;
  assign len_now = std_pal ? 32'(PAL_LEN) : 32'(NTSC_LEN);

  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_en && 32'(pos) == len_now - 1 && !accept_fall) |=> (pos == '0));

  assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clamp_en |=> (clamp_out == $past(sync_in)));

  assert_bypass_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clamp_en |=> !locked);

  assert_clamp_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(clamp_out) && $past(clamp_en)) |-> (32'($past(pos)) == CLAMP_DLY));

  assert_acquire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_en && !locked && fall_evt) |=> (pos == '0));

  assert_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_en && locked && fall_evt && 32'(pos) > FALL_WIN
     && 32'(pos) + 1 + FALL_WIN < len_now) |-> !accept_fall);

  assert_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_good) |-> (32'($past(tip_width)) >= RISE_MIN
                          && 32'($past(tip_width)) <= RISE_MAX));

  assert_lock_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(verdict) && $past(line_good)));

  assert_lock_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(locked) && $past(clamp_en)) |-> ($past(verdict) && !$past(line_good)));

  assert_enable_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp_en) |-> (pos == '0 && !locked));
endmodule

bind hsync_flywheel_clamp hfc_checker #(
  .NTSC_LEN  (NTSC_LEN),
  .PAL_LEN   (PAL_LEN),
  .FALL_WIN  (FALL_WIN),
  .RISE_MIN  (RISE_MIN),
  .RISE_MAX  (RISE_MAX),
  .CLAMP_DLY (CLAMP_DLY),
  .CNT_W     (CNT_W),
  .WID_W     (WID_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sync_in     (sync_in),
  .clamp_en    (clamp_en),
  .std_pal     (std_pal),
  .clamp_out   (clamp_out),
  .locked      (locked),
  .pos         (pos),
  .fall_evt    (fall_evt),
  .accept_fall (accept_fall),
  .verdict     (verdict),
  .tip_width   (tip_width),
  .line_good   (line_good)
);

// File: tb/sim_hsync_flywheel_clamp.sv
`timescale 1ns/1ps
module sim_hsync_flywheel_clamp;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_in = 1'b1;
  logic clamp_en = 1'b0;
  logic std_pal = 1'b0;
  logic clamp_out;
  logic locked;

  localparam int NT = 910;
  localparam int PL = 1136;

  hsync_flywheel_clamp u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_in   (sync_in),
    .clamp_en  (clamp_en),
    .std_pal   (std_pal),
    .clamp_out (clamp_out),
    .locked    (locked)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;
  int    exp_q[$];
  bit    mon_on  = 1'b0;
  logic  prev_c  = 1'b0;
  int    hi_len  = 0;
  string cur_tag = "R1";
  int    t_en    = 0;
  int    last_fall = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: pops the expected clamp start cycles and checks pulse length.
  always @(negedge clk) begin
    if (mon_on) begin
      if (clamp_out && !prev_c) begin
        if (exp_q.size() == 0) check(1'b0, {cur_tag, " unexpected clamp"}, cyc, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          check(cyc == e, {cur_tag, " clamp start"}, cyc, e);
        end
        hi_len = 1;
      end else if (clamp_out) hi_len++;
      else if (prev_c) check(hi_len == 32, "R3 clamp length", hi_len, 32);
    end
    prev_c = clamp_out;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(input bit pal);
    check(exp_q.size() == 0, {cur_tag, " pending clamps"}, exp_q.size(), 0);
    mon_on = 1'b0;
    @(negedge clk);
    clamp_en = 1'b0;
    std_pal = pal;
    tick(3);
    clamp_en = 1'b1;
    t_en = cyc;
    tick(2);
    mon_on = 1'b1;
  endtask

  // Driver: one sync tip, then idle until dur clocks after its falling edge.
  task automatic send_line(input int width, input int dur, input int off);
    last_fall = cyc;
    sync_in = 1'b0;
    if (off >= 0) exp_q.push_back(cyc + off);
    tick(width);
    sync_in = 1'b1;
    tick(dur - width);
  endtask

  initial begin
    logic [7:0] pat;
    pat = 8'b1011_0010;
    tick(3);
    check(clamp_out == 1'b0, "R2 reset clamp_out", clamp_out, 0);
    check(locked == 1'b0, "R2 reset locked", locked, 0);
    rst_n = 1'b1;
    tick(2);

    // R2: bypass with clamp_en low
    for (int i = 0; i < 8; i++) begin
      sync_in = pat[i];
      tick(1);
      check(clamp_out == pat[i], "R2 bypass", clamp_out, pat[i]);
    end
    check(locked == 1'b0, "R2 locked in bypass", locked, 0);
    sync_in = 1'b1;
    tick(2);

    // R9 / R1: flywheel from enable, NTSC then PAL
    cur_tag = "R9";
    restart(1'b0);
    exp_q.push_back(t_en + 91);
    exp_q.push_back(t_en + 91 + NT);
    exp_q.push_back(t_en + 91 + 2 * NT);
    tick(2 * NT + 200);
    cur_tag = "R1";
    check(exp_q.size() == 0, "R1 NTSC period", exp_q.size(), 0);
    check(locked == 1'b0, "R7 no lock without sync", locked, 0);

    restart(1'b1);
    exp_q.push_back(t_en + 91);
    exp_q.push_back(t_en + 91 + PL);
    exp_q.push_back(t_en + 91 + 2 * PL);
    tick(2 * PL + 200);
    check(exp_q.size() == 0, "R1 PAL period", exp_q.size(), 0);

    // R4 acquisition, R7 lock-in
    cur_tag = "R4";
    restart(1'b0);
    tick(8);
    for (int k = 0; k < 6; k++) begin
      check(locked == (k >= 4), "R7 lock after good lines", locked, (k >= 4));
      send_line(70, NT, 93);
      cur_tag = "R7";
    end

    // R5 acceptance window at +-8, rejection at +-9
    cur_tag = "R5";
    send_line(70, NT + 8, 93);
    send_line(70, NT + 9, 93);
    send_line(70, NT - 9, 84);
    send_line(70, NT - 9, 93);
    send_line(70, NT + 9, 102);
    send_line(70, NT - 8, 93);
    send_line(70, NT, 93);
    check(locked == 1'b1, "R5 lock kept", locked, 1);

    // R6 widths just outside the range drop the lock after 8 lines
    cur_tag = "R6";
    for (int k = 0; k < 8; k++) begin
      check(locked == 1'b1, "R6 lock before 8 bad widths", locked, 1);
      send_line((k % 2 == 1) ? 81 : 59, NT, 93);
    end
    check(locked == 1'b0, "R6 bad widths unlock", locked, 0);

    // R6 widths at the limits count as good
    for (int k = 0; k < 4; k++) begin
      check(locked == 1'b0, "R6 R7 relock pending", locked, 0);
      send_line((k % 2 == 1) ? 80 : 60, NT, 93);
    end
    check(locked == 1'b1, "R6 R7 relock on limit widths", locked, 1);

    // R8 sync removed: flywheel clamps continue, lock drops on the 8th empty line
    cur_tag = "R8";
    for (int j = 1; j <= 9; j++) exp_q.push_back(last_fall + j * NT + 93);
    for (int j = 1; j <= 9; j++) begin
      tick(last_fall + j * NT + 200 - cyc);
      check(locked == (j < 8), "R8 lock after missing lines", locked, (j < 8));
    end
    tick(20);
    check(exp_q.size() == 0, "R8 flywheel clamps", exp_q.size(), 0);
    mon_on = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule